// File: doc/BRIEF.md
# Smart-Card T=0 Command Exchange Sequencer

This block runs one command exchange with a smart card in the T=0 style over a byte-wide character link. The host places a command in a small buffer: a five-byte header (class, instruction, two parameters, length byte) followed by an optional payload. The host then pulses `start` with the total command length. The sequencer reads the buffer through its own address port and sends the header. From the class, instruction, parameters and length it decides whether data will flow from the card or to it. It then runs the acknowledge, data and status phases and finishes with a one-cycle `done` pulse that carries the two status bytes and an error flag.

Data bytes that come from the card are streamed out one at a time on the response port, and `rsp_count` counts them. The character link below the block serialises bytes and supplies a wait-time expiry pulse. That pulse closes any receive phase, so a silent card cannot hang the exchange. Bit timing, card activation and retries belong elsewhere.

Top module: `t0_exchange_seq`

## Requirements
- R1: After reset, `busy`, `done`, `error`, `tx_valid` and `rsp_valid` are all low.
- R2: A `start` pulse while idle sends buffer bytes 0 to 4 in order on the transmit port. A byte counts as sent in a cycle where `tx_valid` and `tx_ready` are both high. While `tx_ready` is low, `cmd_rd_addr` and `tx_byte` hold.
- R3: A `start` pulse while `busy` is high is ignored. The header is not sent again and the result of the running exchange is unchanged.
- R4: Card-to-host mode is chosen only when byte 0 is 0xA0 and one of two cases holds. In the first, byte 1 is 0xC0, bytes 2 and 3 are 0x00 and the command length is exactly 5. In the second, byte 1 is 0xB0 or 0xB2 and the length is at least 5. Every other command is host-to-card.
- R5: If byte 4 (the length byte, N) is zero, the two received bytes after the header become `sw1` and `sw2`, with `error` low, in either mode.
- R6: In card-to-host mode with N > 0, the block receives N+3 bytes. The first byte (acknowledge) is not streamed. The next N bytes appear in order on `rsp_byte`, one `rsp_valid` pulse each. The last two become `sw1`/`sw2`, and `rsp_count` equals N.
- R7: In card-to-host mode, a receive phase that closes on wait-time expiry after exactly 2 bytes reports those bytes as `sw1`/`sw2`, with `error` low and no data streamed.
- R8: In host-to-card mode with N > 0, a first received byte equal to byte 1 makes the block send buffer bytes 5 to 4+N. It then takes the next two received bytes as status.
- R9: In host-to-card mode, a first byte that differs from byte 1 followed by a second byte ends the exchange. The two bytes are reported as status, with `error` low and no payload sent.
- R10: Any receive phase that closes on expiry with a count other than the one accepted by R5 to R9 ends with `error` high and `sw1` = `sw2` = 0x00.
- R11: When byte 1 is 0x88, received 0x60 bytes are discarded and not counted, but only in the status phase that follows a payload. For any other instruction, 0x60 counts as a status byte.
- R12: A byte and a wait-time expiry in the same cycle: the byte is counted first, and the expiry is then judged on the updated count.
- R13: `done` is high for exactly one cycle and `busy` is low in the next. `sw1`, `sw2`, `error` and `rsp_count` hold their values until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an exchange (honoured only when idle) |
| cmd_len | input | LEN_W | Total command length in bytes, header included |
| cmd_rd_addr | output | LEN_W | Command buffer read address |
| cmd_rd_data | input | 8 | Command buffer byte at `cmd_rd_addr` (combinational read) |
| tx_valid | output | 1 | Byte offered to the character link |
| tx_byte | output | 8 | Byte to send |
| tx_ready | input | 1 | Link accepts the offered byte |
| rx_valid | input | 1 | Received byte strobe |
| rx_byte | input | 8 | Received byte |
| rx_timeout | input | 1 | Wait-time expiry pulse from the link |
| busy | output | 1 | Exchange in progress |
| done | output | 1 | One-cycle end-of-exchange pulse |
| error | output | 1 | Exchange failed (valid from `done`) |
| sw1 | output | 8 | First status byte |
| sw2 | output | 8 | Second status byte |
| rsp_valid | output | 1 | Response data byte strobe |
| rsp_byte | output | 8 | Response data byte |
| rsp_count | output | CNT_W | Number of data bytes streamed in this exchange |

## Verification
Two events can reach the block in the same cycle: the arrival of a received byte and the wait-time expiry that closes the phase. The bench provokes this by raising `rx_timeout` on the clock that carries the last byte of a reply. In card-to-host mode it does this with a second byte, which must give an early status. With only one byte, the result must be an error. It also raises the expiry on the clock of a final status byte, where the expiry must have no effect. The behavioural model in the bench counts the byte before it judges the expiry, and every outcome is compared with that model.

// File: rtl/t0_seq_pkg.sv
package t0_seq_pkg;

    typedef enum logic [2:0] {
        S_IDLE      = 3'd0,
        S_TX_HDR    = 3'd1,
        S_RX_STAT   = 3'd2,
        S_RX_ACK    = 3'd3,
        S_RX_ACKDAT = 3'd4,
        S_TX_DATA   = 3'd5,
        S_DONE      = 3'd6
    } seq_state_e;

    localparam int         HDR_BYTES  = 5;
    localparam logic [7:0] CLS_GET    = 8'hA0;
    localparam logic [7:0] INS_FETCH  = 8'hC0;
    localparam logic [7:0] INS_RD_BIN = 8'hB0;
    localparam logic [7:0] INS_RD_REC = 8'hB2;
    localparam logic [7:0] INS_ALGO   = 8'h88;
    localparam logic [7:0] NULL_PROC  = 8'h60;

endpackage

// File: rtl/t0_mode_decode.sv
module t0_mode_decode
    import t0_seq_pkg::*;
#(
    parameter int LEN_W = 9
) (
    input  logic [7:0]       cla,
    input  logic [7:0]       ins,
    input  logic [7:0]       p1,
    input  logic [7:0]       p2,
    input  logic [LEN_W-1:0] cmd_len,
    output logic             get_mode
);
    localparam logic [LEN_W-1:0] HDR_LEN = LEN_W'(HDR_BYTES);

    logic fetch_hit;
    logic read_hit;

    always_comb begin
        fetch_hit = (ins == INS_FETCH) && (p1 == 8'h00) && (p2 == 8'h00)
                    && (cmd_len == HDR_LEN);
        read_hit  = ((ins == INS_RD_BIN) || (ins == INS_RD_REC))
                    && (cmd_len >= HDR_LEN);
        get_mode  = (cla == CLS_GET) && (fetch_hit || read_hit);
    end

endmodule

// File: rtl/t0_rx_gate.sv
module t0_rx_gate
    import t0_seq_pkg::*;
(
    input  logic       rx_valid,
    input  logic [7:0] rx_byte,
    input  logic       drop_null,
    output logic       take
);
    always_comb begin
        take = rx_valid && !(drop_null && (rx_byte == NULL_PROC));
    end

endmodule

// File: rtl/t0_exchange_seq.sv
module t0_exchange_seq
    import t0_seq_pkg::*;
#(
    parameter int LEN_W = 9,
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LEN_W-1:0] cmd_len,
    output logic [LEN_W-1:0] cmd_rd_addr,
    input  logic [7:0]       cmd_rd_data,
    output logic             tx_valid,
    output logic [7:0]       tx_byte,
    input  logic             tx_ready,
    input  logic             rx_valid,
    input  logic [7:0]       rx_byte,
    input  logic             rx_timeout,
    output logic             busy,
    output logic             done,
    output logic             error,
    output logic [7:0]       sw1,
    output logic [7:0]       sw2,
    output logic             rsp_valid,
    output logic [7:0]       rsp_byte,
    output logic [CNT_W-1:0] rsp_count
);
    localparam logic [LEN_W-1:0] LAST_HDR  = LEN_W'(HDR_BYTES - 1);
    localparam logic [LEN_W-1:0] FIRST_PAY = LEN_W'(HDR_BYTES);
    localparam logic [CNT_W-1:0] ONE       = CNT_W'(1);
    localparam logic [CNT_W-1:0] TWO       = CNT_W'(2);

    typedef struct packed {
        seq_state_e       st;
        logic [LEN_W-1:0] idx;
        logic [LEN_W-1:0] len;
        logic [7:0]       cla;
        logic [7:0]       ins;
        logic [7:0]       p1;
        logic [7:0]       p2;
        logic [7:0]       p3;
        logic [CNT_W-1:0] rxn;
        logic [7:0]       hold;
        logic [7:0]       sw1;
        logic [7:0]       sw2;
        logic             err;
        logic [CNT_W-1:0] cnt;
        logic             filt;
        logic             rv;
        logic [7:0]       rb;
    } seq_regs_t;

    seq_regs_t        seq_q, seq_d;
    logic             get_mode;
    logic             take;
    logic             fin_ok;
    logic             fin_err;
    logic             ack_hit;
    logic [CNT_W-1:0] p3_w;

    t0_mode_decode #(.LEN_W(LEN_W)) u_dec (
        .cla      (seq_q.cla),
        .ins      (seq_q.ins),
        .p1       (seq_q.p1),
        .p2       (seq_q.p2),
        .cmd_len  (seq_q.len),
        .get_mode (get_mode)
    );

    t0_rx_gate u_gate (
        .rx_valid  (rx_valid),
        .rx_byte   (rx_byte),
        .drop_null (seq_q.filt),
        .take      (take)
    );

    always_comb begin
        seq_d    = seq_q;
        seq_d.rv = 1'b0;
        fin_ok   = 1'b0;
        fin_err  = 1'b0;
        ack_hit  = 1'b0;
        p3_w     = CNT_W'(seq_q.p3);

        case (seq_q.st)
            S_IDLE: begin
                if (start) begin
                    seq_d.st   = S_TX_HDR;
                    seq_d.idx  = '0;
                    seq_d.len  = cmd_len;
                    seq_d.err  = 1'b0;
                    seq_d.sw1  = 8'h00;
                    seq_d.sw2  = 8'h00;
                    seq_d.cnt  = '0;
                    seq_d.filt = 1'b0;
                end
            end
            S_TX_HDR: begin
                if (tx_ready) begin
                    seq_d.idx = seq_q.idx + LEN_W'(1);
                    if (seq_q.idx == LEN_W'(0)) begin
                        seq_d.cla = cmd_rd_data;
                    end else if (seq_q.idx == LEN_W'(1)) begin
                        seq_d.ins = cmd_rd_data;
                    end else if (seq_q.idx == LEN_W'(2)) begin
                        seq_d.p1 = cmd_rd_data;
                    end else if (seq_q.idx == LEN_W'(3)) begin
                        seq_d.p2 = cmd_rd_data;
                    end else if (seq_q.idx == LAST_HDR) begin
                        seq_d.p3  = cmd_rd_data;
                        seq_d.rxn = '0;
                        if (cmd_rd_data == 8'h00) begin
                            seq_d.st = S_RX_STAT;
                        end else if (get_mode) begin
                            seq_d.st = S_RX_ACKDAT;
                        end else begin
                            seq_d.st = S_RX_ACK;
                        end
                    end
                end
            end
            S_RX_STAT: begin
                if (take) begin
                    seq_d.rxn = seq_q.rxn + ONE;
                    if (seq_q.rxn == '0) begin
                        seq_d.sw1 = rx_byte;
                    end else begin
                        seq_d.sw2 = rx_byte;
                        fin_ok    = 1'b1;
                    end
                end
                if (rx_timeout && !fin_ok) begin
                    fin_err = 1'b1;
                end
            end
            S_RX_ACK: begin
                if (take) begin
                    seq_d.rxn = seq_q.rxn + ONE;
                    if (seq_q.rxn == '0) begin
                        seq_d.sw1 = rx_byte;
                        if (rx_byte == seq_q.ins) begin
                            ack_hit   = 1'b1;
                            seq_d.st  = S_TX_DATA;
                            seq_d.idx = FIRST_PAY;
                        end
                    end else begin
                        seq_d.sw2 = rx_byte;
                        fin_ok    = 1'b1;
                    end
                end
                if (rx_timeout && !fin_ok && !ack_hit) begin
                    fin_err = 1'b1;
                end
            end
            S_RX_ACKDAT: begin
                if (take) begin
                    seq_d.rxn = seq_q.rxn + ONE;
                    if (seq_q.rxn == '0) begin
                        seq_d.sw1 = rx_byte;
                    end else if (seq_q.rxn == ONE) begin
                        seq_d.sw2  = rx_byte;
                        seq_d.hold = rx_byte;
                    end else begin
                        if (seq_q.rxn <= p3_w + ONE) begin
                            seq_d.rv  = 1'b1;
                            seq_d.rb  = seq_q.hold;
                            seq_d.cnt = seq_q.cnt + ONE;
                        end
                        if (seq_q.rxn == p3_w + ONE) begin
                            seq_d.sw1 = rx_byte;
                        end else if (seq_q.rxn == p3_w + TWO) begin
                            seq_d.sw2 = rx_byte;
                            fin_ok    = 1'b1;
                        end else begin
                            seq_d.hold = rx_byte;
                        end
                    end
                end
                if (rx_timeout && !fin_ok) begin
                    if (seq_d.rxn == TWO) begin
                        fin_ok = 1'b1;
                    end else begin
                        fin_err = 1'b1;
                    end
                end
            end
            S_TX_DATA: begin
                if (tx_ready) begin
                    seq_d.idx = seq_q.idx + LEN_W'(1);
                    if (seq_q.idx == LAST_HDR + LEN_W'(seq_q.p3)) begin
                        seq_d.st   = S_RX_STAT;
                        seq_d.rxn  = '0;
                        seq_d.filt = (seq_q.ins == INS_ALGO);
                    end
                end
            end
            S_DONE: begin
                seq_d.st = S_IDLE;
            end
            default: begin
                seq_d.st = S_IDLE;
            end
        endcase

        if (fin_ok || fin_err) begin
            seq_d.st   = S_DONE;
            seq_d.filt = 1'b0;
        end
        if (fin_err) begin
            seq_d.err = 1'b1;
            seq_d.sw1 = 8'h00;
            seq_d.sw2 = 8'h00;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign cmd_rd_addr = seq_q.idx;
    assign tx_valid    = (seq_q.st == S_TX_HDR) || (seq_q.st == S_TX_DATA);
    assign tx_byte     = cmd_rd_data;
    assign busy        = (seq_q.st != S_IDLE);
    assign done        = (seq_q.st == S_DONE);
    assign error       = seq_q.err;
    assign sw1         = seq_q.sw1;
    assign sw2         = seq_q.sw2;
    assign rsp_valid   = seq_q.rv;
    assign rsp_byte    = seq_q.rb;
    assign rsp_count   = seq_q.cnt;

endmodule

// File: rtl/t0_exchange_seq_chk.sv
module t0_exchange_seq_chk #(
    parameter int LEN_W = 9,
    parameter int CNT_W = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [LEN_W-1:0] cmd_rd_addr,
    input logic             tx_valid,
    input logic [7:0]       tx_byte,
    input logic             tx_ready,
    input logic             busy,
    input logic             done,
    input logic             error,
    input logic [7:0]       sw1,
    input logic [7:0]       sw2,
    input logic             rsp_valid,
    input logic [CNT_W-1:0] rsp_count
);
    // R2: an offered byte stays put until accepted
    p_tx_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready |=> tx_valid && $stable(cmd_rd_addr) && $stable(tx_byte));

    // R3: an exchange only begins from a start pulse
    p_busy_from_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    // R6: streamed data only inside an exchange, and it is counted
    p_rsp_counted_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> busy && (rsp_count != '0));

    // R10: a failed exchange reports zero status
    p_err_zero_status_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done && error |-> (sw1 == 8'h00) && (sw2 == 8'h00));

    // R13: done is a single pulse followed by idle
    p_done_then_idle_r13: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && !busy);

    // R13: results hold while idle and no start arrives
    p_results_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && !start |=> $stable(sw1) && $stable(sw2) && $stable(error) && $stable(rsp_count));

    // R2: nothing is offered to the link while finishing
    p_no_tx_at_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !tx_valid && !rsp_valid);

endmodule

bind t0_exchange_seq t0_exchange_seq_chk #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/t0_exchange_seq_tb.sv
module t0_exchange_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int LEN_W = 9;
    localparam int CNT_W = 9;
    localparam int MEM_N = 264;

    logic clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [LEN_W-1:0] cmd_len = '0;
    logic [LEN_W-1:0] cmd_rd_addr;
    logic [7:0]       cmd_rd_data;
    logic             tx_valid;
    logic [7:0]       tx_byte;
    logic             tx_ready = 1'b0;
    logic             rx_valid = 1'b0;
    logic [7:0]       rx_byte = 8'h00;
    logic             rx_timeout = 1'b0;
    logic             busy, done, error, rsp_valid;
    logic [7:0]       sw1, sw2, rsp_byte;
    logic [CNT_W-1:0] rsp_count;

    logic [7:0] mem [MEM_N];
    assign cmd_rd_data = (int'(cmd_rd_addr) < MEM_N) ? mem[cmd_rd_addr] : 8'h00;

    t0_exchange_seq #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_dut (.*);

    int n_chk = 0;
    int n_fail = 0;
    int tx_seen = 0;
    int done_cnt = 0;
    bit prev_done = 0;
    bit slow_ready = 0;
    logic [1:0] rdy_cnt = '0;
    logic [7:0] snap_sw1, snap_sw2;
    logic       snap_err;
    int         snap_cnt;
    logic [7:0] exp_tx[$];
    logic [7:0] exp_rsp[$];
    logic [7:0] qa[$];
    logic [7:0] qb[$];

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    always @(posedge clk) begin
        rdy_cnt  <= rdy_cnt + 2'd1;
        tx_ready <= slow_ready ? (rdy_cnt != 2'b01) : 1'b1;
    end

    // per-clock comparison against the bench model's queues
    always @(negedge clk) begin
        if (rst_n) begin
            if (tx_valid && tx_ready) begin
                if (exp_tx.size() == 0) chk(1'b0, "R2", "unexpected tx byte", int'(tx_byte), 0);
                else chk(tx_byte == exp_tx.pop_front(), "R2", "tx byte", int'(tx_byte), 0);
                tx_seen++;
            end
            if (rsp_valid) begin
                if (exp_rsp.size() == 0) chk(1'b0, "R6", "unexpected rsp byte", int'(rsp_byte), 0);
                else chk(rsp_byte == exp_rsp.pop_front(), "R6", "rsp byte", int'(rsp_byte), 0);
            end
            if (prev_done) chk(!busy && !done, "R13", "idle after done", int'(busy), 0);
            prev_done = done;
            if (done) begin
                done_cnt++;
                snap_sw1 = sw1;
                snap_sw2 = sw2;
                snap_err = error;
                snap_cnt = int'(rsp_count);
            end
        end
    end

    task automatic rx_put(input logic [7:0] b, input bit wt);
        @(negedge clk);
        rx_valid   = 1'b1;
        rx_byte    = b;
        rx_timeout = wt;
        @(negedge clk);
        rx_valid   = 1'b0;
        rx_timeout = 1'b0;
    endtask

    // behavioural model plus card stimulus for one exchange
    task automatic run_case(input string req, input logic [7:0] c0, input logic [7:0] c1,
                            input logic [7:0] c2, input logic [7:0] c3, input logic [7:0] c4,
                            input int len, input bit wt_last, input bit poke);
        bit get, pay, eerr, filt;
        logic [7:0] esw1, esw2;
        logic [7:0] st[$];
        int n, ecnt, p3;
        p3 = int'(c4);
        mem[0] = c0; mem[1] = c1; mem[2] = c2; mem[3] = c3; mem[4] = c4;
        get = (c0 == 8'hA0) && (((c1 == 8'hC0) && (c2 == 8'h00) && (c3 == 8'h00) && (len == 5))
              || (((c1 == 8'hB0) || (c1 == 8'hB2)) && (len >= 5)));
        exp_tx.delete();
        exp_rsp.delete();
        for (int k = 0; k < 5; k++) exp_tx.push_back(mem[k]);
        pay = 0; eerr = 0; esw1 = 8'h00; esw2 = 8'h00;
        if (p3 == 0) begin
            if (qa.size() >= 2) begin esw1 = qa[0]; esw2 = qa[1]; end
            else eerr = 1;
        end else if (get) begin
            n = (qa.size() > p3 + 3) ? p3 + 3 : qa.size();
            for (int k = 1; k <= n - 2 && k <= p3; k++) exp_rsp.push_back(qa[k]);
            if (n == p3 + 3) begin esw1 = qa[p3 + 1]; esw2 = qa[p3 + 2]; end
            else if (n == 2) begin esw1 = qa[0]; esw2 = qa[1]; end
            else eerr = 1;
        end else begin
            if (qa.size() >= 1 && qa[0] == c1) begin
                pay = 1;
                for (int k = 0; k < p3; k++) exp_tx.push_back(mem[5 + k]);
                filt = (c1 == 8'h88);
                st.delete();
                foreach (qb[k]) if (!(filt && qb[k] == 8'h60)) st.push_back(qb[k]);
                if (st.size() >= 2) begin esw1 = st[0]; esw2 = st[1]; end
                else eerr = 1;
            end else if (qa.size() >= 2) begin
                esw1 = qa[0]; esw2 = qa[1];
            end else eerr = 1;
        end
        if (eerr) begin esw1 = 8'h00; esw2 = 8'h00; end
        ecnt = exp_rsp.size();

        tx_seen  = 0;
        done_cnt = 0;
        @(negedge clk);
        start = 1'b1;
        cmd_len = LEN_W'(len);
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            start = 1'b1;
            cmd_len = LEN_W'(5);
            @(negedge clk);
            start = 1'b0;
        end
        wait (tx_seen == 5);
        foreach (qa[k]) rx_put(qa[k], wt_last && !pay && (k == qa.size() - 1));
        if (pay) begin
            wait (tx_seen == 5 + p3);
            foreach (qb[k]) rx_put(qb[k], wt_last && (k == qb.size() - 1));
        end
        if (!wt_last) begin
            @(negedge clk);
            rx_timeout = 1'b1;
            @(negedge clk);
            rx_timeout = 1'b0;
        end
        wait (done_cnt > 0);
        repeat (3) @(negedge clk);
        chk(done_cnt == 1, req, "done pulses", done_cnt, 1);
        chk(snap_sw1 == esw1, req, "sw1", int'(snap_sw1), int'(esw1));
        chk(snap_sw2 == esw2, req, "sw2", int'(snap_sw2), int'(esw2));
        chk(snap_err == eerr, req, "error", int'(snap_err), int'(eerr));
        chk(snap_cnt == ecnt, req, "rsp_count", snap_cnt, ecnt);
        chk(exp_tx.size() == 0, req, "tx bytes left", exp_tx.size(), 0);
        chk(exp_rsp.size() == 0, req, "rsp bytes left", exp_rsp.size(), 0);
        chk(!busy && sw1 == esw1 && sw2 == esw2 && error == eerr, "R13", "results held",
            int'({sw1, sw2}), int'({esw1, esw2}));
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        chk(1'b0, "WATCHDOG", "run did not finish", 0, 1);
        summary();
        $finish;
    end

    initial begin
        for (int k = 0; k < MEM_N; k++) mem[k] = 8'(k * 13 + 7);
        repeat (3) @(negedge clk);
        chk(!busy && !done && !error && !tx_valid && !rsp_valid, "R1", "reset outputs",
            int'({busy, done, error, tx_valid, rsp_valid}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !tx_valid, "R1", "idle after release", int'({busy, tx_valid}), 0);

        // R5: zero length, status only
        qa = '{8'h90, 8'h00}; qb.delete();
        run_case("R5", 8'hA0, 8'hA4, 8'h00, 8'h00, 8'h00, 7, 1'b0, 1'b0);
        // R6: read binary with data, slow link
        slow_ready = 1;
        qa = '{8'hB0, 8'h11, 8'h22, 8'h33, 8'h44, 8'h90, 8'h00};
        run_case("R6", 8'hA0, 8'hB0, 8'h00, 8'h00, 8'h04, 5, 1'b0, 1'b0);
        // R4: fetch form with exact length is card-to-host
        qa = '{8'hC0, 8'h5A, 8'hA5, 8'h3C, 8'h91, 8'h08};
        run_case("R4", 8'hA0, 8'hC0, 8'h00, 8'h00, 8'h03, 5, 1'b0, 1'b0);
        // R4: nonzero parameter makes it host-to-card
        qa = '{8'hC0}; qb = '{8'h90, 8'h00};
        run_case("R4", 8'hA0, 8'hC0, 8'h00, 8'h01, 8'h02, 7, 1'b0, 1'b0);
        // R4: length other than 5 makes it host-to-card
        qa = '{8'hC0}; qb = '{8'h90, 8'h01};
        run_case("R4", 8'hA0, 8'hC0, 8'h00, 8'h00, 8'h02, 7, 1'b0, 1'b0);
        // R4: other class is host-to-card even for a read
        qa = '{8'hB0}; qb = '{8'h6D, 8'h00};
        run_case("R4", 8'h00, 8'hB0, 8'h00, 8'h00, 8'h02, 7, 1'b0, 1'b0);
        slow_ready = 0;
        // R7: early status in card-to-host mode
        qa = '{8'h6A, 8'h82};
        run_case("R7", 8'hA0, 8'hB2, 8'h01, 8'h04, 8'h0A, 5, 1'b0, 1'b0);
        // R12: expiry on the same clock as the second byte
        qa = '{8'h6A, 8'h83};
        run_case("R12", 8'hA0, 8'hB2, 8'h01, 8'h04, 8'h0A, 5, 1'b1, 1'b0);
        // R12: expiry with the only byte gives an error
        qa = '{8'h6A};
        run_case("R12", 8'hA0, 8'hB0, 8'h00, 8'h00, 8'h03, 5, 1'b1, 1'b0);
        // R12: expiry on the last status byte has no effect
        qa = '{8'hD6}; qb = '{8'h90, 8'h00};
        run_case("R12", 8'hA0, 8'hD6, 8'h00, 8'h00, 8'h03, 8, 1'b1, 1'b0);
        // R8: payload sent after matching acknowledge
        qa = '{8'hD6}; qb = '{8'h90, 8'h00};
        run_case("R8", 8'hA0, 8'hD6, 8'h00, 8'h10, 8'h05, 10, 1'b0, 1'b0);
        // R9: two-byte reply in place of acknowledge
        qa = '{8'h98, 8'h04}; qb.delete();
        run_case("R9", 8'hA0, 8'hD6, 8'h00, 8'h00, 8'h03, 8, 1'b0, 1'b0);
        // R10: acknowledge mismatch then silence
        qa = '{8'h55};
        run_case("R10", 8'hA0, 8'hD6, 8'h00, 8'h00, 8'h03, 8, 1'b0, 1'b0);
        // R10: short status phase
        qa = '{8'h90};
        run_case("R10", 8'hA0, 8'hA4, 8'h00, 8'h00, 8'h00, 5, 1'b0, 1'b0);
        // R10: card-to-host stream cut short, partial data streamed
        qa = '{8'hB0, 8'h11, 8'h22, 8'h33};
        run_case("R10", 8'hA0, 8'hB0, 8'h00, 8'h00, 8'h04, 5, 1'b0, 1'b0);
        // R11: null bytes dropped for the algorithm instruction
        qa = '{8'h88}; qb = '{8'h60, 8'h60, 8'h9F, 8'h0C};
        run_case("R11", 8'hA0, 8'h88, 8'h00, 8'h00, 8'h10, 21, 1'b0, 1'b0);
        // R11: null byte counts for other instructions
        qa = '{8'hD6}; qb = '{8'h60, 8'h90};
        run_case("R11", 8'hA0, 8'hD6, 8'h00, 8'h00, 8'h02, 7, 1'b0, 1'b0);
        // R3: second start during an exchange is ignored
        qa = '{8'hD6}; qb = '{8'h90, 8'h00};
        run_case("R3", 8'hA0, 8'hD6, 8'h00, 8'h00, 8'h04, 9, 1'b0, 1'b1);

        summary();
        $finish;
    end

endmodule